// File: doc/BRIEF.md
# Butterfly Reverse, OR-Combine and Shuffle Unit

A purely combinational permutation unit for 64-bit words. The datapath is a chain of butterfly stages. Each stage handles one power-of-two distance and is switched on by one bit of a control amount. The same kind of staged network performs four operations:

- **Generalized bit reverse:** each enabled stage swaps adjacent groups.
- **Generalized OR-combine:** each enabled stage ORs the swapped word into the running word.
- **Shuffle (interleave):** the outer stage is applied first.
- **Unshuffle:** the same stages are applied in the opposite order, so it undoes a shuffle with the same control.

A word-mode flag restricts the operation to the low 32 bits. In that mode the upper input half is ignored, the topmost stage cannot be reached, and the upper half of the result is zero. Instruction decode and immediate extraction happen before this block. The caller presents the data, the amount, a 2-bit operation code and the word-mode flag, and takes the result in the same cycle.

Top module: `bfly_perm_unit`

## Requirements
- R1: The operation code `op_i` selects the function: 2'b00 OR-combine, 2'b01 reverse, 2'b10 shuffle, 2'b11 unshuffle. The result is a combinational function of the current inputs, with no state.
- R2: Reverse: result bit i equals input bit (i XOR amt), where amt is the effective amount. Stage k, enabled by amount bit k, swaps adjacent groups of 2^k bits. The number of set bits is therefore preserved.
- R3: In 64-bit mode, reverse with amount 6'b111111 returns the input in fully mirrored bit order (bit 63 to bit 0).
- R4: OR-combine: each enabled stage k replaces the running word x by x OR swap_k(x). Result bit i is therefore the OR of input bits j for all j where (i XOR j) has set bits only where the amount is set. Every input one stays set.
- R5: Shuffle stage k (distance N=2^k) moves the bit at index i to the index with bits k and k+1 of i exchanged. Bits whose index has equal values at bits k and k+1 stay in place. Enabled stages are applied in descending order of k.
- R6: Unshuffle applies the same stages in ascending order of k. Applying unshuffle to a shuffle result with the same amount and mode returns the (mode-masked) original data.
- R7: With `word32_i`=1, `data_i[63:32]` has no effect on the result, and `result_o[63:32]` is zero.
- R8: Effective amount is formed as follows. Reverse and OR-combine use `amount_i[5:0]` in 64-bit mode and `amount_i[4:0]` in word mode. Shuffle and unshuffle use `amount_i[4:0]` in 64-bit mode and `amount_i[3:0]` in word mode. All other amount bits have no effect.
- R9: An effective amount of zero returns the (mode-masked) input unchanged for every operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 64 | Source word |
| amount_i | input | 6 | Stage-enable control amount, bit k enables stage k |
| op_i | input | 2 | Operation code (see R1) |
| word32_i | input | 1 | 1 = operate on the low 32 bits only |
| result_o | output | 64 | Permuted or combined result |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and `result_o`. The bench drives each new input set on the falling clock edge and compares the output 5 ns later, well before the next rising edge. The shuffle-then-unshuffle round trip takes two consecutive stimulus slots: the first result is captured and then fed back as the next input. The bench sweeps every amount value with every operation, in both modes, over several data patterns. Its expected values come from index arithmetic on bit positions rather than from masks.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  localparam int XLEN  = 64;
  localparam int AMT_W = $clog2(XLEN);
  localparam int SHF_W = AMT_W - 1;

  typedef enum logic [1:0] {
    OP_ORC    = 2'b00,
    OP_REV    = 2'b01,
    OP_SHFL   = 2'b10,
    OP_UNSHFL = 2'b11
  } bfly_op_e;

  // Bits whose index has bit k clear: lower member of each 2^k-group pair.
  function automatic logic [XLEN-1:0] pair_low_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = ((i >> k) & 1) == 0;
    return m;
  endfunction

  // Swap adjacent groups of 2^k bits.
  function automatic logic [XLEN-1:0] pair_swap(input logic [XLEN-1:0] x, input int k);
    logic [XLEN-1:0] m;
    int s;
    m = pair_low_mask(k);
    s = 1 << k;
    return ((x & m) << s) | ((x & ~m) >> s);
  endfunction

  // Destination positions of the left-moving half of an interleave stage.
  function automatic logic [XLEN-1:0] ilv_left_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++)
      m[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
    return m;
  endfunction

  // Destination positions of the right-moving half of an interleave stage.
  function automatic logic [XLEN-1:0] ilv_right_mask(input int k);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++)
      m[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    return m;
  endfunction

  // One interleave stage at distance 2^k; self-inverse.
  function automatic logic [XLEN-1:0] ilv_stage(input logic [XLEN-1:0] x, input int k);
    logic [XLEN-1:0] ml, mr;
    int n;
    ml = ilv_left_mask(k);
    mr = ilv_right_mask(k);
    n  = 1 << k;
    return (x & ~(ml | mr)) | ((x << n) & ml) | ((x >> n) & mr);
  endfunction
endpackage

// File: rtl/bfly_swap_chain.sv
// Reverse / OR-combine butterfly chain, stage k enabled by amt_i[k].
module bfly_swap_chain #(
  parameter int W      = bfly_pkg::XLEN,
  parameter int STAGES = bfly_pkg::AMT_W
) (
  input  logic [W-1:0]      data_i,
  input  logic [STAGES-1:0] amt_i,
  input  logic              or_mode_i,
  output logic [W-1:0]      data_o
);
  logic [W-1:0] chain [0:STAGES];

  assign chain[0] = data_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] swapped;
    logic         stage_on;
    assign swapped      = bfly_pkg::pair_swap(chain[g], g);
    assign stage_on     = amt_i[g];
    assign chain[g+1]   = !stage_on ? chain[g]
                        : (or_mode_i ? (chain[g] | swapped) : swapped);
  end

  assign data_o = chain[STAGES];

  logic chain_idle;
  assign chain_idle = (amt_i == '0);

  always_comb begin
    if (chain_idle)
      AST_SWAP_IDLE_PASSES: assert (data_o == data_i); // R9
  end
endmodule

// File: rtl/bfly_ilv_chain.sv
// Interleave chain; REVERSE_ORDER=0 runs stages high to low (shuffle),
// REVERSE_ORDER=1 runs them low to high (unshuffle).
module bfly_ilv_chain #(
  parameter int W             = bfly_pkg::XLEN,
  parameter int STAGES        = bfly_pkg::SHF_W,
  parameter bit REVERSE_ORDER = 1'b0
) (
  input  logic [W-1:0]      data_i,
  input  logic [STAGES-1:0] amt_i,
  output logic [W-1:0]      data_o
);
  logic [W-1:0] chain [0:STAGES];

  assign chain[0] = data_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int K = REVERSE_ORDER ? g : (STAGES - 1 - g);
    logic [W-1:0] moved;
    assign moved      = bfly_pkg::ilv_stage(chain[g], K);
    assign chain[g+1] = amt_i[K] ? moved : chain[g];
  end

  assign data_o = chain[STAGES];

  logic ilv_idle;
  assign ilv_idle = (amt_i == '0);

  always_comb begin
    if (ilv_idle)
      AST_ILV_IDLE_PASSES: assert (data_o == data_i); // R9
    AST_ILV_KEEPS_ONES: assert ($countones(data_o) == $countones(data_i)); // R5
  end
endmodule

// File: rtl/bfly_perm_unit.sv
module bfly_perm_unit #(
  parameter int W     = bfly_pkg::XLEN,
  parameter int AMT_W = bfly_pkg::AMT_W
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic [1:0]       op_i,
  input  logic             word32_i,
  output logic [W-1:0]     result_o
);
  import bfly_pkg::*;

  localparam int HALF  = W / 2;
  localparam int SH_W  = AMT_W - 1;

  bfly_op_e op;
  assign op = bfly_op_e'(op_i);

  // Mode masking of data and amounts.
  logic [W-1:0]     src;
  logic [AMT_W-1:0] swap_amt;
  logic [SH_W-1:0]  ilv_amt;

  assign src      = word32_i ? {{HALF{1'b0}}, data_i[HALF-1:0]} : data_i;
  assign swap_amt = word32_i ? {1'b0, amount_i[AMT_W-2:0]} : amount_i;
  assign ilv_amt  = word32_i ? {1'b0, amount_i[SH_W-2:0]} : amount_i[SH_W-1:0];

  logic [W-1:0] swap_res, shfl_res, unshfl_res;

  bfly_swap_chain #(.W(W), .STAGES(AMT_W)) u_swap (
    .data_i    (src),
    .amt_i     (swap_amt),
    .or_mode_i (op == OP_ORC),
    .data_o    (swap_res)
  );

  bfly_ilv_chain #(.W(W), .STAGES(SH_W), .REVERSE_ORDER(1'b0)) u_shfl (
    .data_i (src),
    .amt_i  (ilv_amt),
    .data_o (shfl_res)
  );

  bfly_ilv_chain #(.W(W), .STAGES(SH_W), .REVERSE_ORDER(1'b1)) u_unshfl (
    .data_i (src),
    .amt_i  (ilv_amt),
    .data_o (unshfl_res)
  );

  always_comb begin
    unique case (op)
      OP_ORC, OP_REV: result_o = swap_res;
      OP_SHFL:        result_o = shfl_res;
      OP_UNSHFL:      result_o = unshfl_res;
      default:        result_o = swap_res;
    endcase
  end

  // Observation signals for the checks below.
  logic [W-1:0] src_mirror;
  logic         full_reverse;
  logic         is_perm;

  always_comb begin
    for (int i = 0; i < W; i++) src_mirror[i] = src[W-1-i];
  end
  assign full_reverse = (op == OP_REV) && !word32_i && (amount_i == '1);
  assign is_perm      = (op != OP_ORC);

  always_comb begin
    if (word32_i)
      AST_WORD_UPPER_CLEAR: assert (result_o[W-1:HALF] == '0); // R7
    if (full_reverse)
      AST_FULL_MIRROR: assert (result_o == src_mirror); // R3
    if (op == OP_ORC)
      AST_ORC_KEEPS_ONES: assert ((result_o & src) == src); // R4
    if (is_perm)
      AST_PERM_ONES_COUNT: assert ($countones(result_o) == $countones(src)); // R2
  end
endmodule

// File: tb/bfly_perm_unit_tb_top.sv
module bfly_perm_unit_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n;
  logic [63:0] data;
  logic [5:0]  amount;
  logic [1:0]  op;
  logic        word32;
  logic [63:0] result;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  bfly_perm_unit dut_i (
    .data_i   (data),
    .amount_i (amount),
    .op_i     (op),
    .word32_i (word32),
    .result_o (result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d, input int a, input int o, input bit w);
    @(negedge clk);
    data   = d;
    amount = a[5:0];
    op     = o[1:0];
    word32 = w;
    #5;
  endtask

  function automatic logic [63:0] ref_rev(input logic [63:0] x, input int a);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[i ^ a];
    return r;
  endfunction

  function automatic logic [63:0] ref_orc(input logic [63:0] x, input int a);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        if ((((i ^ j) & ~a) & 63) == 0) r[i] = r[i] | x[j];
    return r;
  endfunction

  function automatic int idx_swap(input int i, input int k);
    int lo, hi, r;
    lo = (i >> k) & 1;
    hi = (i >> (k + 1)) & 1;
    r  = i & ~((1 << k) | (1 << (k + 1)));
    return r | (lo << (k + 1)) | (hi << k);
  endfunction

  function automatic logic [63:0] ref_ilv(input logic [63:0] x, input int a, input bit undo);
    logic [63:0] y, t;
    y = x;
    for (int step = 0; step < 5; step++) begin
      int k;
      k = undo ? step : 4 - step;
      if (((a >> k) & 1) == 1) begin
        for (int i = 0; i < 64; i++) t[i] = y[idx_swap(i, k)];
        y = t;
      end
    end
    return y;
  endfunction

  function automatic logic [63:0] pattern(input int p);
    case (p)
      0: return 64'h0123_4567_89AB_CDEF;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0001;
      3: return 64'hF00D_0000_0000_0A50;
      4: return 64'h5A5A_C3C3_0F0F_1248;
      default: return {32'(p * 32'h9E37_79B9), 32'(p * 32'h85EB_CA6B)};
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n  = 1'b0;
    data   = '0;
    amount = '0;
    op     = 2'b01;
    word32 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    check("R9 zero input after reset", result, 64'h0);

    // Full sweep: patterns x modes x operations x every amount.
    for (int p = 0; p < 8; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int o = 0; o < 4; o++) begin
          for (int a = 0; a < 64; a++) begin
            logic [63:0] src, exp;
            int          eff;
            string       tag;
            src = (w == 1) ? {32'h0, pattern(p)[31:0]} : pattern(p);
            if (o < 2) eff = (w == 1) ? (a & 31) : a;
            else       eff = (w == 1) ? (a & 15) : (a & 31);
            case (o)
              0:       begin exp = ref_orc(src, eff);     tag = "R4"; end
              1:       begin exp = ref_rev(src, eff);     tag = "R2"; end
              2:       begin exp = ref_ilv(src, eff, 0);  tag = "R5"; end
              default: begin exp = ref_ilv(src, eff, 1);  tag = "R6"; end
            endcase
            if (eff != a)  tag = {tag, " R8"};
            if (w == 1)    tag = {tag, " R7"};
            if (eff == 0)  tag = {tag, " R9"};
            drive(pattern(p), a, o, w[0]);
            check($sformatf("R1 %s op=%0d amt=%0d w32=%0d pat=%0d", tag, o, a, w, p),
                  result, exp);
          end
        end
      end
    end

    // R3: full mirror in 64-bit mode.
    for (int p = 0; p < 8; p++) begin
      logic [63:0] mir;
      for (int i = 0; i < 64; i++) mir[i] = pattern(p)[63 - i];
      drive(pattern(p), 63, 1, 1'b0);
      check($sformatf("R3 full mirror pat=%0d", p), result, mir);
    end

    // R6: shuffle then unshuffle round trip, both modes.
    for (int w = 0; w < 2; w++) begin
      for (int a = 0; a < 32; a++) begin
        logic [63:0] mid, orig;
        orig = (w == 1) ? {32'h0, pattern(a % 8)[31:0]} : pattern(a % 8);
        drive(pattern(a % 8), a, 2, w[0]);
        mid = result;
        drive(mid, a, 3, w[0]);
        check($sformatf("R6 round trip amt=%0d w32=%0d", a, w), result, orig);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule